// File: doc/BRIEF.md
# Lockable Color Subcarrier Phase Accumulator

This block produces the running phase of a video color subcarrier. A 32-bit accumulator adds a frequency increment on every clock. The phase word it outputs feeds a sine/cosine stage further down the chip. Normally the increment comes from a register value held outside the block.

A shared control pin is given a role by a two-bit mode input. In restart mode, a rising edge on the pin arms a restart. The phase then returns to zero at the next field boundary, and a field-zero flag marks that field. In lock mode, the pin carries a serial frame from an external video source. The frame holds a 22-bit frequency value. Once a complete frame has arrived, that value replaces the register increment at the next line start. This lets the subcarrier follow line-length variation line by line. When lock mode is used, the register increment is expected to be programmed to zero.

Top module: `subcarrierPhaseGen`

## Requirements
- R1: After each rising clock edge, `phase` equals its previous value plus the selected increment, modulo 2^32, unless a restart applies at that edge.
- R2: Mode encoding on `modeSel`: 2'b00 and 2'b11 make the pin unused, 2'b01 is restart mode and 2'b10 is lock mode. In every mode other than lock, the increment is `freqWord`, and pin activity has no effect on `phase` or `fieldZero`.
- R3: In restart mode, a low-to-high pin edge arms a restart. At the clock edge that samples `fieldStart` high while armed, `phase` becomes 0 and `fieldZero` goes to 1. `fieldZero` returns to 0 at the next `fieldStart` that brings no restart.
- R4: A restart never happens before the field boundary. It does not happen without an edge seen in restart mode. An arm is dropped when the mode leaves restart mode.
- R5: A further pin edge while armed neither moves the restart nor adds a second one. Exactly one field boundary zeroes the phase per arm.
- R6: A lock frame is a start bit (a rising edge after the pin has been low) followed by 67 data bits, data bit 0 first, each lasting 2 clocks and sampled in its second clock. Data bits 0..21 form the frequency value with bit 0 as LSB. Data bits 22..66 are ignored.
- R7: In lock mode, the increment is the received 22-bit value placed in increment bits 31..10, with bits 9..0 zero. It takes effect only at a `lineStart` after a complete frame, and one frame is applied only once. A `lineStart` with no complete frame pending changes nothing. On each entry into lock mode the increment starts at 0.
- R8: In lock mode, `freqWord` has no effect on the phase step.
- R9: While `rstN` is low, `phase` is 0 and `fieldZero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Role of the control pin (R2 encoding) |
| freqWord | input | 32 | Register frequency increment |
| ctlPin | input | 1 | Shared control pin, asynchronous |
| lineStart | input | 1 | One-cycle pulse at the start of each line |
| fieldStart | input | 1 | One-cycle pulse at the start of each field |
| phase | output | 32 | Subcarrier phase word |
| fieldZero | output | 1 | High during the field that began with a restart |

## Verification
A change of `freqWord`, or an applied lock value, first shows in the phase difference between the two falling edges that follow the next rising edge. The bench therefore measures a step as the difference of two consecutive falling-edge samples, taken only after that edge. A restart shows at the first falling edge after the rising edge that samples `fieldStart`: `phase` reads 0 there and advances by one step at the next falling edge. Pin edges pass through three registers before they act. The bench therefore waits several cycles after every pin change before it applies a boundary or a line start, and it keeps the frame bit timing relative to the start edge only.

// File: rtl/scpPkg.sv
package scpPkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_LOCK    = 2'b10,
    MODE_SPARE   = 2'b11
  } pinMode_e;

  typedef struct packed {
    logic zeroPhase;
    logic loadLock;
    logic useLock;
  } scpStrobe_t;
endpackage

// File: rtl/scpLockRx.sv
module scpLockRx #(
  parameter int FRAME_BITS = 67,
  parameter int FREQ_BITS  = 22,
  parameter int BIT_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 bitIn,
  input  logic                 startEdge,
  output logic                 frameDone,
  output logic [FREQ_BITS-1:0] frameValue
);
  localparam int IDX_W    = $clog2(FRAME_BITS + 1);
  localparam int SLOT_W   = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int MID_SLOT = BIT_CYCLES / 2;
  localparam int LAST_SLOT = BIT_CYCLES - 1;

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic [FREQ_BITS-1:0] capReg;

  assign frameValue = capReg;

  // idx 0 is the start bit; data bit k lives in idx k+1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      slot      <= '0;
      idx       <= '0;
      capReg    <= '0;
      frameDone <= 1'b0;
    end else if (!enable) begin
      busy      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!busy) begin
        if (startEdge) begin
          busy <= 1'b1;
          slot <= SLOT_W'(1);
          idx  <= '0;
        end
      end else begin
        if (slot == SLOT_W'(LAST_SLOT)) begin
          slot <= '0;
          idx  <= idx + IDX_W'(1);
        end else begin
          slot <= slot + SLOT_W'(1);
        end
        if (slot == SLOT_W'(MID_SLOT) && idx != '0) begin
          for (int b = 0; b < FREQ_BITS; b++) begin
            if (idx == IDX_W'(b + 1)) capReg[b] <= bitIn;
          end
          if (idx == IDX_W'(FRAME_BITS)) begin
            busy      <= 1'b0;
            frameDone <= 1'b1;
          end
        end
      end
    end
  end

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idx <= IDX_W'(FRAME_BITS)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
endmodule

// File: rtl/scpControl.sv
module scpControl
  import scpPkg::*;
#(
  parameter int FRAME_BITS = 67,
  parameter int FREQ_BITS  = 22,
  parameter int BIT_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 ctlPin,
  input  logic                 lineStart,
  input  logic                 fieldStart,
  output scpStrobe_t           strobe,
  output logic [FREQ_BITS-1:0] lockValue
);
  pinMode_e mode;
  logic syncA, syncB, prevLvl, pinRise;
  logic armed;
  logic lockEn, rstEn;
  logic rxDone;
  logic [FREQ_BITS-1:0] rxValue;
  logic pendingValid;
  logic [FREQ_BITS-1:0] pendingVal;

  assign mode   = pinMode_e'(modeSel);
  assign lockEn = (mode == MODE_LOCK);
  assign rstEn  = (mode == MODE_RESTART);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncA   <= ctlPin;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end
  assign pinRise = syncB & ~prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN)                     armed <= 1'b0;
    else if (!rstEn)               armed <= 1'b0;
    else if (fieldStart && armed)  armed <= 1'b0;
    else if (pinRise)              armed <= 1'b1;
  end

  scpLockRx #(
    .FRAME_BITS(FRAME_BITS),
    .FREQ_BITS (FREQ_BITS),
    .BIT_CYCLES(BIT_CYCLES)
  ) uRx (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (lockEn),
    .bitIn     (syncB),
    .startEdge (pinRise),
    .frameDone (rxDone),
    .frameValue(rxValue)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingValid <= 1'b0;
      pendingVal   <= '0;
    end else if (!lockEn) begin
      pendingValid <= 1'b0;
    end else begin
      if (lineStart && pendingValid) pendingValid <= 1'b0;
      if (rxDone) begin
        pendingValid <= 1'b1;
        pendingVal   <= rxValue;
      end
    end
  end

  assign lockValue        = pendingVal;
  assign strobe.useLock   = lockEn;
  assign strobe.loadLock  = lockEn && lineStart && pendingValid;
  assign strobe.zeroPhase = rstEn && fieldStart && armed;

  a_r5_one_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroPhase |=> !armed);
  a_r7_apply_once: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLock && !rxDone) |=> !pendingValid);
  a_r4_arm_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (!rstEn) |=> !armed);
endmodule

// File: rtl/scpDatapath.sv
module scpDatapath
  import scpPkg::*;
#(
  parameter int PHASE_W   = 32,
  parameter int FREQ_BITS = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PHASE_W-1:0]   freqWord,
  input  logic                 fieldStart,
  input  scpStrobe_t           strobe,
  input  logic [FREQ_BITS-1:0] lockValue,
  output logic [PHASE_W-1:0]   phase,
  output logic                 fieldZero
);
  localparam int PAD = PHASE_W - FREQ_BITS;

  logic [PHASE_W-1:0] lockInc;
  logic [PHASE_W-1:0] incSel;

  always_ff @(posedge clk) begin
    if (!rstN)                lockInc <= '0;
    else if (!strobe.useLock) lockInc <= '0;
    else if (strobe.loadLock) lockInc <= {lockValue, {PAD{1'b0}}};
  end

  assign incSel = strobe.useLock ? lockInc : freqWord;

  always_ff @(posedge clk) begin
    if (!rstN)                 phase <= '0;
    else if (strobe.zeroPhase) phase <= '0;
    else                       phase <= phase + incSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 fieldZero <= 1'b0;
    else if (strobe.zeroPhase) fieldZero <= 1'b1;
    else if (fieldStart)       fieldZero <= 1'b0;
  end

  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.zeroPhase)) |-> (phase == $past(phase) + $past(incSel)));
  a_r3_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroPhase |=> (phase == '0 && fieldZero));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.useLock) && strobe.useLock && !$past(strobe.loadLock))
      |-> $stable(lockInc));
endmodule

// File: rtl/subcarrierPhaseGen.sv
module subcarrierPhaseGen
  import scpPkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int FRAME_BITS = 67,
  parameter int FREQ_BITS  = 22,
  parameter int BIT_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               ctlPin,
  input  logic               lineStart,
  input  logic               fieldStart,
  output logic [PHASE_W-1:0] phase,
  output logic               fieldZero
);
  scpStrobe_t           strobe;
  logic [FREQ_BITS-1:0] lockValue;

  scpControl #(
    .FRAME_BITS(FRAME_BITS),
    .FREQ_BITS (FREQ_BITS),
    .BIT_CYCLES(BIT_CYCLES)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .ctlPin    (ctlPin),
    .lineStart (lineStart),
    .fieldStart(fieldStart),
    .strobe    (strobe),
    .lockValue (lockValue)
  );

  scpDatapath #(
    .PHASE_W  (PHASE_W),
    .FREQ_BITS(FREQ_BITS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .freqWord  (freqWord),
    .fieldStart(fieldStart),
    .strobe    (strobe),
    .lockValue (lockValue),
    .phase     (phase),
    .fieldZero (fieldZero)
  );
endmodule

// File: tb/sim_subcarrierPhaseGen.sv
`timescale 1ns/1ps
module sim_subcarrierPhaseGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [31:0] freqWord = '0;
  logic        ctlPin = 1'b0;
  logic        lineStart = 1'b0;
  logic        fieldStart = 1'b0;
  logic [31:0] phase;
  logic        fieldZero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  subcarrierPhaseGen u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .freqWord(freqWord),
    .ctlPin(ctlPin), .lineStart(lineStart), .fieldStart(fieldStart),
    .phase(phase), .fieldZero(fieldZero)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stepOf(output logic [31:0] d);
    logic [31:0] p1;
    tick(); p1 = phase;
    tick(); d = phase - p1;
  endtask

  task automatic pulseField();
    fieldStart = 1'b1; tick(); fieldStart = 1'b0;
  endtask

  task automatic pulseLine();
    lineStart = 1'b1; tick(); lineStart = 1'b0;
  endtask

  task automatic pinRise();
    ctlPin = 1'b0; tick(4); ctlPin = 1'b1; tick(6);
  endtask

  // start bit, then 67 data bits (bit 0 first), 2 clocks each; optional line pulse at bit cut
  task automatic sendFrame(input logic [66:0] fr, input int cut);
    ctlPin = 1'b0; tick(4);
    ctlPin = 1'b1; tick(2);
    for (int i = 0; i < 67; i++) begin
      ctlPin = fr[i];
      if (i == cut) lineStart = 1'b1;
      tick();
      lineStart = 1'b0;
      tick();
    end
    ctlPin = 1'b0; tick(8);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p, expInc, prevInc;
    logic [21:0] vals [0:13];
    logic [44:0] garb;

    tick(5);
    chk("R9 phase in reset", phase, 32'd0);
    chk("R9 fieldZero in reset", {31'd0, fieldZero}, 32'd0);
    rstN = 1'b1;

    // R1/R2: register increment sweep in both unused-pin encodings
    for (int m = 0; m < 2; m++) begin
      modeSel = (m == 0) ? 2'b00 : 2'b11;
      for (int k = 0; k < 16; k++) begin
        freqWord = (k == 15) ? 32'hFFFF_FFFF : (32'h0111_1111 * k) ^ (32'h8000_0000 >> k);
        tick();
        stepOf(d);
        chk("R1 step equals freqWord", d, freqWord);
      end
    end

    // R2: pin edge and boundary ignored in an unused mode
    modeSel = 2'b00; freqWord = 32'h0100_0000;
    tick();
    pinRise();
    p = phase; pulseField();
    chk("R2 no restart when pin unused", phase, p + 32'h0100_0000);
    chk("R2 fieldZero stays low", {31'd0, fieldZero}, 32'd0);

    // R4: edge in other mode then switching to restart mode does not arm
    modeSel = 2'b01; tick(3);
    p = phase; pulseField();
    chk("R4 no restart without edge in mode", phase, p + 32'h0100_0000);

    // R3/R4: arm, wait, then boundary
    pinRise();
    stepOf(d);
    chk("R4 no early restart", d, 32'h0100_0000);
    chk("R4 fieldZero low before boundary", {31'd0, fieldZero}, 32'd0);
    pulseField();
    chk("R3 phase zero after boundary", phase, 32'd0);
    chk("R3 fieldZero set", {31'd0, fieldZero}, 32'd1);
    tick();
    chk("R3 resumes stepping", phase, 32'h0100_0000);
    p = phase; pulseField();
    chk("R5 one restart per arm", phase, p + 32'h0100_0000);
    chk("R3 fieldZero clears at next field", {31'd0, fieldZero}, 32'd0);

    // R5: second edge while armed
    pinRise();
    pinRise();
    stepOf(d);
    chk("R5 second edge no early restart", d, 32'h0100_0000);
    pulseField();
    chk("R5 restart at boundary", phase, 32'd0);
    tick(2);
    p = phase; pulseField();
    chk("R5 no second restart", phase, p + 32'h0100_0000);

    // R4: arm dropped on mode change
    pinRise();
    modeSel = 2'b00; tick(2); modeSel = 2'b01; tick(2);
    p = phase; pulseField();
    chk("R4 arm dropped by mode change", phase, p + 32'h0100_0000);

    // Lock mode
    ctlPin = 1'b0; tick(4);
    modeSel = 2'b10; freqWord = 32'h1234_5678;
    tick();
    stepOf(d);
    chk("R8 freqWord ignored, R7 start at zero", d, 32'd0);

    vals[0] = 22'h3FFFFF; vals[1] = 22'h000001; vals[2] = 22'h200000;
    vals[3] = 22'h155555; vals[4] = 22'h2AAAAA;
    for (int k = 5; k < 14; k++) vals[k] = 22'((k * 32'h04F1B3) ^ (32'h1 << k));
    prevInc = 32'd0;
    for (int k = 0; k < 14; k++) begin
      garb = (k % 2 == 0) ? {45{1'b1}} : {23{2'b10}};
      sendFrame({garb, vals[k]}, -1);
      stepOf(d);
      chk("R7 not applied before line start", d, prevInc);
      pulseLine();
      expInc = {vals[k], 10'd0};
      stepOf(d);
      chk("R6 R7 lock increment", d, expInc);
      freqWord = freqWord + 32'h0F0F_0F0F;
      pulseLine();
      stepOf(d);
      chk("R7 R8 line start with nothing pending", d, expInc);
      prevInc = expInc;
    end

    // R7: line start during an incomplete frame
    sendFrame({45'd0, 22'h0ABCDE}, 30);
    stepOf(d);
    chk("R7 mid-frame line start ignored", d, prevInc);
    pulseLine();
    stepOf(d);
    chk("R7 frame applied at later line", d, {22'h0ABCDE, 10'd0});

    // R7: re-entry into lock starts at zero
    modeSel = 2'b00; tick(2); modeSel = 2'b10; tick();
    stepOf(d);
    chk("R7 re-entry clears increment", d, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule